// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a data cache controller that sits between a CPU port and a word-wide external memory port. The CPU port carries 20-bit word addresses and 16-bit data. Each CPU read or write is looked up in a single cache line, chosen by the middle bits of the address. A hit is served from the on-chip data array. A miss moves whole blocks between the cache and external memory, one word per memory transfer.

Writes use write-allocate and write-back together. A write miss first brings the block into the cache and then merges the write data into it. A write hit touches only the cache and marks the line dirty. When a miss lands on a dirty line, the old block is written out to external memory before the new block is read in. Eight event counters record CPU reads and writes, external memory reads and writes, and read and write hits and misses. Both the number of lines and the block length are parameters.

Top module: `cc_dm_cache_ctrl`

## Requirements
- R1: After synchronous reset, all eight counters read 0, `cpu_ready` and `mem_req` are low, and every line is invalid, so the first access to any line misses.
- R2: An address splits into an offset (low log2(WORDS) bits), a line index (next log2(LINES) bits) and a tag (the remaining upper bits). Two addresses with the same index but different tags compete for one line.
- R3: A read hit returns the cached word with no external memory transfer. It adds one to the CPU-read counter and one to the read-hit counter.
- R4: A miss reads the WORDS words of the new block from external memory, at addresses {tag, index, k} for k = 0 up to WORDS-1 in ascending order. A read miss then returns the addressed word.
- R5: A write hit updates only the cached word and marks the line dirty. It makes no external transfer, and it adds to the CPU-write counter and the write-hit counter.
- R6: A write miss fills the block first and then merges the write data into it. Afterwards the line is dirty, and a later read of that address returns the written value.
- R7: A miss on a valid dirty line first writes the WORDS words of the old block to {old tag, index, k}, for k ascending, with their current cached values. Only after that does the new block's fill start.
- R8: A fill leaves the line clean unless the access was a write. A read miss on a clean or invalid line makes no external write.
- R9: `cpu_ready` is a one-cycle pulse that ends each access, and `cpu_rdata` is valid with it. `cpu_ready` is never high while `mem_req` is high. The CPU holds its request until the pulse and then drops it.
- R10: Every external transfer is one word. `mem_req` holds address, direction and write data stable until `mem_ack`, and drops on the cycle after the acknowledge.
- R11: Each counter rises by exactly one for each of its events. The external read and write counters rise on each acknowledged transfer of their direction. Hits plus misses of each kind equal the CPU accesses of that kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | External transfer request |
| mem_we | output | 1 | External transfer direction, 1 = write |
| mem_addr | output | ADDR_W | External word address |
| mem_wdata | output | DATA_W | External write data |
| mem_ack | input | 1 | External transfer acknowledge |
| mem_rdata | input | DATA_W | External read data, valid with `mem_ack` |
| cnt_cpu_rd | output | CNT_W | CPU read count |
| cnt_cpu_wr | output | CNT_W | CPU write count |
| cnt_ext_rd | output | CNT_W | External read transfer count |
| cnt_ext_wr | output | CNT_W | External write transfer count |
| cnt_rd_hit | output | CNT_W | Read hit count |
| cnt_rd_miss | output | CNT_W | Read miss count |
| cnt_wr_hit | output | CNT_W | Write hit count |
| cnt_wr_miss | output | CNT_W | Write miss count |

## Verification
Each kind of corrupted internal state has a visible symptom at the ports. A wrong valid, tag or dirty bit shows up on the very next access to that line, as an unexpected or missing burst on the memory port and a hit or miss counter that no longer matches. A wrong word in the data array stays hidden until that word is read back or written out by a victim writeback. The bench therefore follows dirty data all the way round: write, evict, and read again. A broken word counter or address build shows within one burst, as an address out of sequence or as a burst of the wrong length.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_RESP, ST_WB_RD, ST_WB_SEND, ST_WB_WAIT, ST_FILL_REQ, ST_FILL_WAIT
  } cc_state_e;

  localparam int NUM_EV      = 8;
  localparam int EV_CPU_RD   = 0;
  localparam int EV_CPU_WR   = 1;
  localparam int EV_EXT_RD   = 2;
  localparam int EV_EXT_WR   = 3;
  localparam int EV_RD_HIT   = 4;
  localparam int EV_RD_MISS  = 5;
  localparam int EV_WR_HIT   = 6;
  localparam int EV_WR_MISS  = 7;
endpackage

// File: rtl/cc_tag_store.sv
module cc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 14,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // R1: valid and dirty clear on reset; tags need no reset
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        dirty_q[fill_idx] <= 1'b0;   // R8
      end
      if (dirty_en) dirty_q[dirty_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/cc_data_ram.sv
module cc_data_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cc_event_counters.sv
module cc_event_counters #(
  parameter int NUM   = 8,
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM-1:0]            inc,
  output logic [NUM-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)         cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;   // R11
    end
  end
endmodule

// File: rtl/cc_dm_cache_ctrl.sv
module cc_dm_cache_ctrl
  import cc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  cnt_cpu_rd,
  output logic [CNT_W-1:0]  cnt_cpu_wr,
  output logic [CNT_W-1:0]  cnt_ext_rd,
  output logic [CNT_W-1:0]  cnt_ext_wr,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int DEPTH  = LINES * WORDS;
  localparam int RAM_AW = IDX_W + OFF_W;
  localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS - 1);

  cc_state_e         state;
  logic              req_we;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W-1:0]  req_off;
  logic [DATA_W-1:0] req_wdata;
  logic              missed;
  logic [OFF_W-1:0]  wcnt;

  logic              ln_valid, ln_dirty;
  logic [TAG_W-1:0]  ln_tag;
  logic              hit, last, accept, fill_done, wr_hit_now;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_q;
  logic [NUM_EV-1:0] ev_inc;
  logic [NUM_EV-1:0][CNT_W-1:0] ev_cnt;

  // R2: tag | index | offset
  assign hit        = ln_valid && (ln_tag == req_tag);
  assign last       = (wcnt == LAST_WORD);
  assign accept     = (state == ST_IDLE) && cpu_req && !cpu_ready;
  assign fill_done  = (state == ST_FILL_WAIT) && mem_ack && last;
  assign wr_hit_now = (state == ST_LOOKUP) && hit && req_we;

  cc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (req_idx),
    .rd_valid (ln_valid),
    .rd_dirty (ln_dirty),
    .rd_tag   (ln_tag),
    .fill_en  (fill_done),
    .fill_idx (req_idx),
    .fill_tag (req_tag),
    .dirty_en (wr_hit_now),      // R5, R6: set on hit or on post-fill merge
    .dirty_idx(req_idx)
  );

  always_comb begin
    ram_we    = wr_hit_now || ((state == ST_FILL_WAIT) && mem_ack);
    ram_waddr = (state == ST_FILL_WAIT) ? {req_idx, wcnt} : {req_idx, req_off};
    ram_wdata = (state == ST_FILL_WAIT) ? mem_rdata : req_wdata;
    ram_raddr = (state == ST_WB_RD) ? {req_idx, wcnt} : {req_idx, req_off};
  end

  cc_data_ram #(.DEPTH(DEPTH), .DW(DATA_W)) u_data (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(ram_raddr),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      missed    <= 1'b0;
      wcnt      <= '0;
      req_we    <= 1'b0;
      req_tag   <= '0;
      req_idx   <= '0;
      req_off   <= '0;
      req_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          req_we    <= cpu_we;
          req_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
          req_idx   <= cpu_addr[OFF_W +: IDX_W];
          req_off   <= cpu_addr[OFF_W-1:0];
          req_wdata <= cpu_wdata;
          missed    <= 1'b0;
          state     <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            if (req_we) begin
              cpu_ready <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              state <= ST_RESP;
            end
          end else begin
            missed <= 1'b1;
            wcnt   <= '0;
            state  <= (ln_valid && ln_dirty) ? ST_WB_RD : ST_FILL_REQ;  // R7, R8
          end
        end
        ST_RESP: begin
          cpu_rdata <= ram_q;
          cpu_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_WB_RD: state <= ST_WB_SEND;
        ST_WB_SEND: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= {ln_tag, req_idx, wcnt};
          mem_wdata <= ram_q;
          state     <= ST_WB_WAIT;
        end
        ST_WB_WAIT: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          if (last) begin
            wcnt  <= '0;
            state <= ST_FILL_REQ;
          end else begin
            wcnt  <= wcnt + 1'b1;
            state <= ST_WB_RD;
          end
        end
        ST_FILL_REQ: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= {req_tag, req_idx, wcnt};
          state    <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: if (mem_ack) begin
          mem_req <= 1'b0;
          if (last) begin
            wcnt  <= '0;
            state <= ST_LOOKUP;          // re-lookup now hits
          end else begin
            wcnt  <= wcnt + 1'b1;
            state <= ST_FILL_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: event sources
  always_comb begin
    ev_inc             = '0;
    ev_inc[EV_CPU_RD]  = accept && !cpu_we;
    ev_inc[EV_CPU_WR]  = accept && cpu_we;
    ev_inc[EV_EXT_RD]  = (state == ST_FILL_WAIT) && mem_ack;
    ev_inc[EV_EXT_WR]  = (state == ST_WB_WAIT) && mem_ack;
    ev_inc[EV_RD_HIT]  = (state == ST_LOOKUP) && !missed && hit && !req_we;
    ev_inc[EV_RD_MISS] = (state == ST_LOOKUP) && !missed && !hit && !req_we;
    ev_inc[EV_WR_HIT]  = (state == ST_LOOKUP) && !missed && hit && req_we;
    ev_inc[EV_WR_MISS] = (state == ST_LOOKUP) && !missed && !hit && req_we;
  end

  cc_event_counters #(.NUM(NUM_EV), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(ev_inc), .cnt(ev_cnt)
  );

  assign cnt_cpu_rd  = ev_cnt[EV_CPU_RD];
  assign cnt_cpu_wr  = ev_cnt[EV_CPU_WR];
  assign cnt_ext_rd  = ev_cnt[EV_EXT_RD];
  assign cnt_ext_wr  = ev_cnt[EV_EXT_WR];
  assign cnt_rd_hit  = ev_cnt[EV_RD_HIT];
  assign cnt_rd_miss = ev_cnt[EV_RD_MISS];
  assign cnt_wr_hit  = ev_cnt[EV_WR_HIT];
  assign cnt_wr_miss = ev_cnt[EV_WR_MISS];
endmodule

// File: rtl/cc_dm_cache_ctrl_chk.sv
module cc_dm_cache_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [CNT_W-1:0]  cnt_cpu_rd,
  input logic [CNT_W-1:0]  cnt_ext_rd,
  input logic [CNT_W-1:0]  cnt_ext_wr,
  input logic [CNT_W-1:0]  cnt_rd_hit,
  input logic [CNT_W-1:0]  cnt_rd_miss
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cnt_cpu_rd == '0 && cnt_ext_rd == '0 && !cpu_ready && !mem_req));

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  p_ready_not_in_xfer_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_req_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);

  p_ext_rd_step_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we) |=> (cnt_ext_rd == $past(cnt_ext_rd) + 1'b1));

  p_ext_rd_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && mem_ack && !mem_we) |=> $stable(cnt_ext_rd));

  p_ext_wr_step_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_we) |=> (cnt_ext_wr == $past(cnt_ext_wr) + 1'b1));

  p_ext_wr_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && mem_ack && mem_we) |=> $stable(cnt_ext_wr));

  p_rd_balance_r11: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_rd_hit} + {1'b0, cnt_rd_miss}) <= {1'b0, cnt_cpu_rd});
endmodule

bind cc_dm_cache_ctrl cc_dm_cache_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_ready  (cpu_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .cnt_cpu_rd (cnt_cpu_rd),
  .cnt_ext_rd (cnt_ext_rd),
  .cnt_ext_wr (cnt_ext_wr),
  .cnt_rd_hit (cnt_rd_hit),
  .cnt_rd_miss(cnt_rd_miss)
);

// File: tb/cc_dm_cache_ctrl_tb.sv
`timescale 1ns/1ps
module cc_dm_cache_ctrl_tb;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int LINES  = 16;
  localparam int WORDS  = 4;
  localparam int CNT_W  = 32;
  localparam int OFF_W  = 2;
  localparam int IDX_W  = 4;

  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata = '0;
  logic [CNT_W-1:0] c_crd, c_cwr, c_erd, c_ewr, c_rh, c_rm, c_wh, c_wm;

  always #2.5 clk = ~clk;

  cc_dm_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cnt_cpu_rd(c_crd), .cnt_cpu_wr(c_cwr), .cnt_ext_rd(c_erd), .cnt_ext_wr(c_ewr),
    .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // external memory model with varying latency, and transfer log
  logic [DATA_W-1:0] ext_mem [int unsigned];
  logic              log_we   [64];
  logic [ADDR_W-1:0] log_addr [64];
  logic [DATA_W-1:0] log_data [64];
  int log_n = 0, lat_cnt = 0, lat_tgt = 0;

  function automatic logic [DATA_W-1:0] ext_peek(input logic [ADDR_W-1:0] a);
    if (ext_mem.exists(int'(a))) return ext_mem[int'(a)];
    return a[15:0] ^ 16'hA5C3 ^ {12'h000, a[19:16]};
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (lat_cnt >= lat_tgt) begin
        if (log_n < 64) begin
          log_we[log_n] = mem_we; log_addr[log_n] = mem_addr;
          log_data[log_n] = mem_we ? mem_wdata : ext_peek(mem_addr);
        end
        log_n++;
        if (mem_we) ext_mem[int'(mem_addr)] = mem_wdata;
        else        mem_rdata = ext_peek(mem_addr);
        mem_ack = 1; lat_cnt = 0; lat_tgt = (lat_tgt + 1) % 3;
      end else lat_cnt++;
    end
  end

  // bench reference of the cache contents and counters
  bit                ref_valid [LINES];
  bit                ref_dirty [LINES];
  int                ref_tag   [LINES];
  logic [DATA_W-1:0] ref_data  [LINES][WORDS];
  longint            e_cnt [8];

  function automatic longint dut_cnt(input int e);
    case (e)
      0: return c_crd; 1: return c_cwr; 2: return c_erd; 3: return c_ewr;
      4: return c_rh;  5: return c_rm;  6: return c_wh;  default: return c_wm;
    endcase
  endfunction

  task automatic check_counters(input string req);
    for (int e = 0; e < 8; e++) chk(dut_cnt(e) == e_cnt[e], req, $sformatf("counter %0d", e), dut_cnt(e), e_cnt[e]);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < LINES; i++) begin ref_valid[i] = 0; ref_dirty[i] = 0; end
    for (int e = 0; e < 8; e++) e_cnt[e] = 0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(cpu_ready == 0, "R1", "cpu_ready after reset", cpu_ready, 0);
    chk(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
    check_counters("R1");
  endtask

  // one CPU access, checked against the reference (R2..R11)
  task automatic do_access(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int idx = int'((a >> OFF_W) % LINES);
    int off = int'(a % WORDS);
    int tg  = int'(a >> (OFF_W + IDX_W));
    bit hit = ref_valid[idx] && ref_tag[idx] == tg;
    bit wb  = !hit && ref_valid[idx] && ref_dirty[idx];
    logic              x_we [64];
    logic [ADDR_W-1:0] x_addr [64];
    logic [DATA_W-1:0] x_data [64];
    int xn = 0, waited = 0, bad = -1;
    logic [DATA_W-1:0] got;
    if (wb) for (int k = 0; k < WORDS; k++) begin   // R7: victim words, ascending
      x_we[xn] = 1; x_addr[xn] = ADDR_W'((ref_tag[idx] << (OFF_W+IDX_W)) | (idx << OFF_W) | k);
      x_data[xn] = ref_data[idx][k]; xn++;
    end
    if (!hit) for (int k = 0; k < WORDS; k++) begin // R4: fill words, ascending
      x_we[xn] = 0; x_addr[xn] = ADDR_W'((tg << (OFF_W+IDX_W)) | (idx << OFF_W) | k);
      x_data[xn] = ext_peek(x_addr[xn]); ref_data[idx][k] = x_data[xn]; xn++;
    end
    if (!hit) begin ref_valid[idx] = 1; ref_tag[idx] = tg; ref_dirty[idx] = 0; end  // R8
    if (we) begin ref_data[idx][off] = d; ref_dirty[idx] = 1; end                   // R5, R6
    e_cnt[we ? 1 : 0]++;
    e_cnt[we ? (hit ? 6 : 7) : (hit ? 4 : 5)]++;
    if (wb) e_cnt[3] += WORDS;
    if (!hit) e_cnt[2] += WORDS;

    log_n = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do begin @(negedge clk); waited++; end while (!cpu_ready && waited < 2000);
    chk(cpu_ready == 1, "R9", "cpu_ready seen", cpu_ready, 1);
    got = cpu_rdata;
    cpu_req = 0;
    @(negedge clk);
    chk(cpu_ready == 0, "R9", "cpu_ready one-cycle pulse", cpu_ready, 0);
    if (!we) chk(got == ref_data[idx][off], "R3/R6", $sformatf("read data @%0h", a), got, ref_data[idx][off]);
    chk(log_n == xn, "R4/R7/R8", $sformatf("transfer count @%0h", a), log_n, xn);
    for (int i = 0; i < xn && i < log_n; i++)
      if (bad < 0 && (log_we[i] != x_we[i] || log_addr[i] != x_addr[i] || log_data[i] != x_data[i])) bad = i;
    chk(bad < 0, "R2/R4/R7", $sformatf("transfer %0d addr @%0h", bad, a),
        bad < 0 ? 0 : log_addr[bad], bad < 0 ? 0 : x_addr[bad]);
    check_counters("R11");
  endtask

  // stimulus table: {we, addr, wdata}
  localparam int NV = 13;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 20'h0004C, 16'h0000},  // R1 R4: cold read miss, tag 1 line 3
    {1'b0, 20'h0004D, 16'h0000},  // R3: read hit
    {1'b1, 20'h0004E, 16'h1234},  // R5: write hit, dirty
    {1'b0, 20'h0004E, 16'h0000},  // R3: read back merged word
    {1'b0, 20'h0008C, 16'h0000},  // R2 R7: same line, tag 2, dirty victim
    {1'b0, 20'h0004E, 16'h0000},  // R8: clean victim, reads 1234 from memory
    {1'b1, 20'h000C1, 16'hBEEF},  // R6: write miss on invalid line 0
    {1'b0, 20'h000C1, 16'h0000},  // R6: read of merged word hits
    {1'b1, 20'h00101, 16'hCAFE},  // R6 R7: write miss over dirty line
    {1'b0, 20'h000C1, 16'h0000},  // R7: BEEF returns from memory
    {1'b0, 20'hFFFFF, 16'h0000},  // R2: top address, largest tag, line 15
    {1'b1, 20'hFFFFC, 16'h7E57},  // R5: write hit, offset 0
    {1'b0, 20'h0003F, 16'h0000}   // R7: tag 0 evicts largest-tag dirty block
  };

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) do_access(VEC[i][36], VEC[i][35:16], VEC[i][15:0]);
    // R1: reset mid-run drops all lines; the next access to a resident line misses
    do_reset();
    do_access(1'b0, 20'h0004E, 16'h0000);
    do_access(1'b0, 20'h0004F, 16'h0000);   // R3: hit after refill
    do_access(1'b1, 20'h0003C, 16'hAAAA);   // R6: write miss, line 15 after reset
    do_access(1'b0, 20'hFFFFD, 16'h0000);   // R7: dirty victim written back
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule